// File: doc/BRIEF.md
# I2C Status Flag Register

This block keeps the eight event flags of an I2C controller's status register. The bus engine, the address comparator and the shift logic sit outside it and report what happens on the bus through single-cycle strobes and a few level inputs. These include SCL rising edges, the ninth clock of a byte, start and stop detection, buffer transfers and mode changes. From these the block sets its flags. Some set conditions depend on whether the controller runs the I2C format or the clock-synchronous serial format.

Software clears a flag with a two-step handshake. It first reads the status register and sees the flag at 1, then writes 0 to that bit. A write of 0 without that earlier read is ignored. Three flags also clear as a side effect of data-buffer access: reading the receive buffer clears receive-full, and writing the transmit buffer clears both transmit-empty and transmit-end. A hardware set in the same cycle as any clear keeps the flag at 1.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset all eight flags read 0. Bit positions in `flags` are: 0 general call, 1 own-address match, 2 arbitration lost / overrun, 3 stop seen, 4 no-acknowledge, 5 receive full, 6 transmit end, 7 transmit empty.
- R2: A status write with bit i at 0 clears flag i only if a status read has returned 1 in bit i since the last status write. Writing 1 to a bit never changes it. Every status write disarms all read markers. A read in the same cycle as a write arms markers for later writes only.
- R3: The general-call, address-match and stop strobes set flags 0, 1 and 3.
- R4: In I2C format with master mode selected, flag 2 sets in two cases. The first is an SCL rising edge in transmit mode where the driven SDA differs from the SDA pin. The second is a start detection while the SDA pin is high.
- R5: In clock-synchronous format, flag 2 sets when the last bit of a received unit arrives while flag 5 is 1. The I2C set conditions of R4 are then ignored.
- R6: Flag 5 sets when received data moves into the receive buffer, and clears on a receive-buffer read.
- R7: Flag 6 sets in two ways. In I2C format it sets on the ninth SCL rising edge while flag 7 is 1. In clock-synchronous format it sets when the last transmit bit has been shifted out.
- R8: Flag 7 sets on any of four events: a transmit-buffer-to-shifter transfer, selection of transmit mode, a start or repeated start, or a change from slave receive to slave transmit.
- R9: A transmit-buffer write clears flags 6 and 7.
- R10: Flag 4 sets on a missing acknowledge only while acknowledge checking is enabled. `halt` is 1 exactly when flag 4 is 1 and checking is enabled.
- R11: When a set event and any clear fall in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_fmt | input | 1 | 1 = clock-synchronous format, 0 = I2C format |
| is_master | input | 1 | Master mode selected |
| is_xmit | input | 1 | Transmit mode selected |
| ack_chk_en | input | 1 | Acknowledge checking enabled |
| ev_gcall | input | 1 | General call address detected |
| ev_addr_hit | input | 1 | Own slave address matched |
| ev_scl_rise | input | 1 | SCL rising edge |
| sda_drv | input | 1 | SDA value the controller drives |
| sda_pin | input | 1 | Sampled SDA pin level |
| ev_start | input | 1 | Start or repeated start detected |
| ev_stop | input | 1 | Stop condition detected |
| ev_nack | input | 1 | Acknowledge bit sampled high after a sent byte |
| ev_rx_load | input | 1 | Shift register moved into receive buffer |
| ev_last_rx | input | 1 | Last bit of a received unit arrived (synchronous format) |
| ev_ninth | input | 1 | Ninth SCL rising edge of a byte |
| ev_last_tx | input | 1 | Last transmit bit shifted out (synchronous format) |
| ev_tx_load | input | 1 | Transmit buffer moved into shift register |
| ev_tx_sel | input | 1 | Transmit mode was selected |
| ev_srx2stx | input | 1 | Slave receive changed to slave transmit |
| st_rd | input | 1 | CPU status register read |
| st_wr | input | 1 | CPU status register write |
| st_wdata | input | 8 | CPU status write data |
| rxbuf_rd | input | 1 | CPU receive buffer read |
| txbuf_wr | input | 1 | CPU transmit buffer write |
| flags | output | 8 | Status flags |
| halt | output | 1 | Transfer halted by no-acknowledge |

## Verification
The assertions take every strobe and level input to be known and sampled on the rising edge, with the value it holds there. They make no assumption about how events overlap: any mix of strobes, reads and writes in one cycle is legal. The bench changes inputs only on the falling edge. It runs directed sequences for each set path, handshake order and side-effect clear, and then a long stretch of random strobes and CPU accesses. The random stretch keeps every input at 0 or 1 and lets events collide with clears freely. This exercises the set-wins rule and the read-then-write marker across mode changes.

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags #(
  parameter int NFLAG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_fmt,
  input  logic             is_master,
  input  logic             is_xmit,
  input  logic             ack_chk_en,
  input  logic             ev_gcall,
  input  logic             ev_addr_hit,
  input  logic             ev_scl_rise,
  input  logic             sda_drv,
  input  logic             sda_pin,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_nack,
  input  logic             ev_rx_load,
  input  logic             ev_last_rx,
  input  logic             ev_ninth,
  input  logic             ev_last_tx,
  input  logic             ev_tx_load,
  input  logic             ev_tx_sel,
  input  logic             ev_srx2stx,
  input  logic             st_rd,
  input  logic             st_wr,
  input  logic [NFLAG-1:0] st_wdata,
  input  logic             rxbuf_rd,
  input  logic             txbuf_wr,
  output logic [NFLAG-1:0] flags,
  output logic             halt
);
  localparam int B_GC = 0, B_AD = 1, B_AL = 2, B_SP = 3, B_NK = 4, B_RF = 5, B_TE = 6, B_TD = 7;

  logic [NFLAG-1:0] armed, set_v, clr_v;
  logic al_i2c, al_ovr;

  assign al_i2c = is_master & ((ev_scl_rise & is_xmit & (sda_drv ^ sda_pin)) | (ev_start & sda_pin));
  assign al_ovr = ev_last_rx & flags[B_RF];

  always_comb begin
    set_v       = '0;
    set_v[B_GC] = ev_gcall;
    set_v[B_AD] = ev_addr_hit;
    set_v[B_AL] = sync_fmt ? al_ovr : al_i2c;
    set_v[B_SP] = ev_stop;
    set_v[B_NK] = ev_nack & ack_chk_en;
    set_v[B_RF] = ev_rx_load;
    set_v[B_TE] = sync_fmt ? ev_last_tx : (ev_ninth & flags[B_TD]);
    set_v[B_TD] = ev_tx_load | ev_tx_sel | ev_start | ev_srx2stx;
  end

  always_comb begin
    clr_v       = st_wr ? (armed & ~st_wdata) : '0;
    clr_v[B_RF] = clr_v[B_RF] | rxbuf_rd;
    clr_v[B_TE] = clr_v[B_TE] | txbuf_wr;
    clr_v[B_TD] = clr_v[B_TD] | txbuf_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= set_v | (flags & ~clr_v);
      armed <= (st_wr ? '0 : armed) | (st_rd ? flags : '0);
    end
  end

  assign halt = flags[B_NK] & ack_chk_en;

  // R3
  stop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_stop |=> flags[B_SP]);
  // R2
  gc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[B_GC] && !(st_wr && armed[B_GC] && !st_wdata[B_GC])) |=> flags[B_GC]);
  // R2
  wr_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n) (st_wr && !st_rd) |=> (armed == '0));
  // R6
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (rxbuf_rd && !ev_rx_load) |=> !flags[B_RF]);
  // R9
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txbuf_wr && !ev_tx_load && !ev_tx_sel && !ev_start && !ev_srx2stx) |=> !flags[B_TD]);
  // R10
  nack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[B_NK] && !(ev_nack && ack_chk_en)) |=> !flags[B_NK]);
  // R11
  rx_setwins_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_rx_load |=> flags[B_RF]);
  // R1
  always_ff @(posedge clk) if (!rst_n) ;
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (flags == '0));
endmodule

// File: tb/i2c_stat_flags_tb.sv
`timescale 1ns/1ps
module i2c_stat_flags_tb;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic sync_fmt = 0, is_master = 0, is_xmit = 0, ack_chk_en = 0;
  logic ev_gcall = 0, ev_addr_hit = 0, ev_scl_rise = 0, sda_drv = 0, sda_pin = 0;
  logic ev_start = 0, ev_stop = 0, ev_nack = 0, ev_rx_load = 0, ev_last_rx = 0;
  logic ev_ninth = 0, ev_last_tx = 0, ev_tx_load = 0, ev_tx_sel = 0, ev_srx2stx = 0;
  logic st_rd = 0, st_wr = 0, rxbuf_rd = 0, txbuf_wr = 0;
  logic [7:0] st_wdata = 0;
  logic [7:0] flags;
  logic halt;

  i2c_stat_flags u_dut (.*);

  int checks = 0, errors = 0;
  bit [7:0] m = 0, mk = 0;

  always @(posedge clk) begin
    bit [7:0] n;
    bit [7:0] k;
    if (!rst_n) begin m = 0; mk = 0; end
    else begin
      n = m; k = mk;
      if (st_wr) begin
        for (int i = 0; i < 8; i++) if (mk[i] && !st_wdata[i]) n[i] = 0;
        k = 0;
      end
      if (st_rd) k = k | m;
      if (rxbuf_rd) n[5] = 0;
      if (txbuf_wr) begin n[6] = 0; n[7] = 0; end
      if (ev_gcall) n[0] = 1;
      if (ev_addr_hit) n[1] = 1;
      if (ev_stop) n[3] = 1;
      if (ev_nack && ack_chk_en) n[4] = 1;
      if (ev_rx_load) n[5] = 1;
      if (sync_fmt) begin
        if (ev_last_rx && m[5]) n[2] = 1;
        if (ev_last_tx) n[6] = 1;
      end else begin
        if (is_master && is_xmit && ev_scl_rise && (sda_drv != sda_pin)) n[2] = 1;
        if (is_master && ev_start && sda_pin) n[2] = 1;
        if (ev_ninth && m[7]) n[6] = 1;
      end
      if (ev_tx_load || ev_tx_sel || ev_start || ev_srx2stx) n[7] = 1;
      m = n; mk = k;
    end
  end

  function automatic string tagof(int i);
    case (i)
      0, 1, 3: return "R3";
      2: return sync_fmt ? "R5" : "R4";
      4: return "R10";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, bit c, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_in();
    ev_gcall = 0; ev_addr_hit = 0; ev_scl_rise = 0; ev_start = 0; ev_stop = 0; ev_nack = 0;
    ev_rx_load = 0; ev_last_rx = 0; ev_ninth = 0; ev_last_tx = 0; ev_tx_load = 0;
    ev_tx_sel = 0; ev_srx2stx = 0; st_rd = 0; st_wr = 0; rxbuf_rd = 0; txbuf_wr = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < 8; i++)
      chk({tagof(i), " model bit"}, flags[i] === m[i], {1'b0, flags}, {1'b0, m});
    chk("R10 halt", halt === (m[4] & ack_chk_en), {8'h0, halt}, {8'h0, m[4] & ack_chk_en});
    clr_in();
  endtask

  task automatic expect_f(string tag, logic [7:0] exp);
    chk(tag, flags === exp, {1'b0, flags}, {1'b0, exp});
  endtask

  task automatic hs_clear(logic [7:0] wd);
    st_rd = 1; tick();
    st_wr = 1; st_wdata = wd; tick();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    expect_f("R1 reset", 8'h00);
    rst_n = 1; tick();
    expect_f("R1 idle", 8'h00);

    ev_stop = 1; ev_gcall = 1; tick();
    expect_f("R3 stop+gc", 8'h09);
    st_wr = 1; st_wdata = 8'h00; tick();
    expect_f("R2 write0 unread", 8'h09);
    st_rd = 1; tick();
    st_wr = 1; st_wdata = 8'hFF; tick();
    expect_f("R2 write1 no effect", 8'h09);
    st_wr = 1; st_wdata = 8'h00; tick();
    expect_f("R2 disarmed after write", 8'h09);
    hs_clear(8'h01);
    expect_f("R2 selective clear", 8'h01);
    ev_addr_hit = 1; tick();
    st_rd = 1; tick();
    st_wr = 1; st_wdata = 8'h00; st_rd = 1; tick();
    expect_f("R2 read-write same cycle", 8'h00);

    is_master = 1; is_xmit = 1; ev_scl_rise = 1; sda_drv = 1; sda_pin = 0; tick();
    expect_f("R4 mismatch", 8'h04);
    hs_clear(8'h00);
    ev_scl_rise = 1; sda_drv = 1; sda_pin = 1; tick();
    expect_f("R4 match no AL", 8'h00);
    ev_start = 1; sda_pin = 1; tick();
    expect_f("R4 start sda high", 8'h84);
    hs_clear(8'h00);

    sync_fmt = 1; ev_rx_load = 1; tick();
    ev_last_rx = 1; ev_scl_rise = 1; sda_drv = 0; sda_pin = 1; tick();
    expect_f("R5 overrun", 8'h24);
    rxbuf_rd = 1; tick();
    expect_f("R6 rx read clears", 8'h04);
    ev_last_rx = 1; tick();
    expect_f("R5 no overrun when empty", 8'h04);
    ev_last_tx = 1; tick();
    expect_f("R7 sync last tx", 8'h44);
    hs_clear(8'h00);

    sync_fmt = 0; ev_ninth = 1; tick();
    expect_f("R7 ninth without tdre", 8'h00);
    ev_tx_sel = 1; tick();
    ev_ninth = 1; tick();
    expect_f("R7 ninth with tdre", 8'hC0);
    txbuf_wr = 1; tick();
    expect_f("R9 tx write clears", 8'h00);
    ev_srx2stx = 1; tick();
    expect_f("R8 slave rx to tx", 8'h80);
    txbuf_wr = 1; ev_tx_load = 1; tick();
    expect_f("R11 set beats clear", 8'h80);
    rxbuf_rd = 1; ev_rx_load = 1; tick();
    expect_f("R11 rx set beats read", 8'hA0);

    ack_chk_en = 0; ev_nack = 1; tick();
    expect_f("R10 nack ignored", 8'hA0);
    ack_chk_en = 1; ev_nack = 1; tick();
    expect_f("R10 nack set", 8'hB0);
    chk("R10 halt high", halt === 1'b1, {8'h0, halt}, 9'h1);
    ack_chk_en = 0; tick();
    chk("R10 halt follows enable", halt === 1'b0, {8'h0, halt}, 9'h0);

    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) sync_fmt = ~sync_fmt;
      is_master = $urandom_range(0, 1); is_xmit = $urandom_range(0, 1);
      ack_chk_en = $urandom_range(0, 1);
      sda_drv = $urandom_range(0, 1); sda_pin = $urandom_range(0, 1);
      ev_gcall = ($urandom_range(0, 15) == 0); ev_addr_hit = ($urandom_range(0, 15) == 0);
      ev_scl_rise = ($urandom_range(0, 7) == 0); ev_start = ($urandom_range(0, 15) == 0);
      ev_stop = ($urandom_range(0, 15) == 0); ev_nack = ($urandom_range(0, 7) == 0);
      ev_rx_load = ($urandom_range(0, 7) == 0); ev_last_rx = ($urandom_range(0, 7) == 0);
      ev_ninth = ($urandom_range(0, 7) == 0); ev_last_tx = ($urandom_range(0, 15) == 0);
      ev_tx_load = ($urandom_range(0, 15) == 0); ev_tx_sel = ($urandom_range(0, 31) == 0);
      ev_srx2stx = ($urandom_range(0, 31) == 0);
      st_rd = ($urandom_range(0, 3) == 0); st_wr = ($urandom_range(0, 3) == 0);
      st_wdata = 8'($urandom);
      rxbuf_rd = ($urandom_range(0, 7) == 0); txbuf_wr = ($urandom_range(0, 7) == 0);
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule